// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Core

This block collects up to 32 interrupt sources and turns them into two request lines for a processor: a normal request and a critical request. Each source is configured by software. It can be edge- or level-sensitive, it can be enabled or masked, and it can be steered to either output. A raw status register latches the events. Software clears status bits through one register offset and sets them through another. A separate read-only view returns only the pending sources that are enabled.

Software reaches the block through a small register port. The port has a word address, write data, read data, and single-cycle read and write strobes. The register window starts at a base address set by a parameter. A level-sensitive source that is still asserted cannot be cleared away: a clear write brings its status bit straight back. An edge-sensitive source latches once for each rising transition and then stays latched until software clears it.

Top module: `intc_dual_core`

## Requirements
- R1: After reset, every stored register (status, enable, critical-select, polarity, trigger-type) reads as zero, both request outputs are low and the read data is zero.
- R2: Source n drives register bit NUM_SRC-1-n, so source 0 is the most significant bit. The window occupies BASE_ADDR+0 through BASE_ADDR+8, with these offsets: 0 status/clear, 1 status/set, 2 enable, 3 critical-select, 4 polarity, 5 trigger-type, 6 masked status.
- R3: A source whose trigger-type bit is 1 sets its status bit on a 0-to-1 input transition, once per transition. A low or steadily high input leaves the bit unchanged.
- R4: A source whose trigger-type bit is 0 copies its input level into its status bit whenever the input changes.
- R5: A write to offset 0 clears each status bit written as 1. Any bit whose level-sensitive input is held high is set again in the same update.
- R6: A write to offset 1 ORs the write data into status. Reads of offset 0 and offset 1 both return status.
- R7: A read of offset 6 returns status AND enable. Writes to offset 6 and offset 7 change no register and no output.
- R8: The normal request is high one clock after (status AND enable AND NOT critical-select) is nonzero, and low one clock after it becomes zero.
- R9: The critical request is high one clock after (status AND enable AND critical-select) is nonzero, and low one clock after it becomes zero.
- R10: The polarity register stores any written value and reads it back. It has no effect on either request output.
- R11: Addresses outside the window (below the base, or at offset 9 and above) read as zero and ignore writes. Offsets 7 and 8 read as zero and ignore writes.
- R12: Read data is registered. It shows the addressed register as it stood at the clock edge where the read strobe is sampled, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, index n is source n |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | NUM_SRC | Registered read data |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
The bench builds the core with NUM_SRC at 32, ADDR_W at 10 and BASE_ADDR moved to 0x140. Moving the base tests the address subtraction and the lower-bound check, because an address just below the window then decodes to a large offset. The full 32-source width brings both ends of the reversed bit order into reach, and it lets one register word mix edge and level sources, enabled and masked sources, and normal and critical routing.

// File: rtl/intc_dual_pkg.sv
package intc_dual_pkg;

  localparam int unsigned OFS_W   = 4;
  localparam int unsigned NUM_OFS = 9;

  typedef enum logic [OFS_W-1:0] {
    OFS_STAT     = 4'd0,
    OFS_STAT_SET = 4'd1,
    OFS_ENABLE   = 4'd2,
    OFS_CRIT_SEL = 4'd3,
    OFS_POLAR    = 4'd4,
    OFS_TRIG     = 4'd5,
    OFS_MASKED   = 4'd6,
    OFS_VEC      = 4'd7,
    OFS_VEC_CFG  = 4'd8
  } reg_ofs_e;

endpackage

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
  import intc_dual_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 'hC0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_ofs_e          ofs
);

  localparam logic [ADDR_W-1:0] BASE_L  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LIMIT_L = ADDR_W'(NUM_OFS);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel = addr - BASE_L;
    hit = (addr >= BASE_L) && (rel < LIMIT_L);
    ofs = hit ? reg_ofs_e'(rel[OFS_W-1:0]) : OFS_STAT;
  end

endmodule

// File: rtl/intc_status_bank.sv
module intc_status_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_bits,
  input  logic [NUM_SRC-1:0] trig_edge,
  input  logic               clr_we,
  input  logic               set_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] status_o
);

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] hold_q, hold_d;
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] sw_base, rise, chg;

  // Software writes come first, then input events for this cycle.
  always_comb begin
    sw_base = status_q;
    if (clr_we) sw_base = (sw_base & ~wdata) | hold_q;
    if (set_we) sw_base = sw_base | wdata;
    rise     = src_bits & ~src_q;
    chg      = src_bits ^ src_q;
    status_d = (trig_edge & (sw_base | rise))
             | (~trig_edge & ((chg & src_bits) | (~chg & sw_base)));
    hold_d   = (trig_edge & hold_q) | (~trig_edge & src_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      hold_q   <= '0;
      status_q <= '0;
    end else begin
      src_q    <= src_bits;
      hold_q   <= hold_d;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && src_bits[i] && !src_q[i]) |=> status_q[i]);
    assert_edge_low_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[i] && !src_bits[i] && !clr_we && !set_we) |=> $stable(status_q[i]));
    assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_edge[i] && (src_bits[i] != src_q[i])) |=> (status_q[i] == $past(src_bits[i])));
    assert_clear_reasserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && hold_q[i] && !set_we && (trig_edge[i] || (src_bits[i] == src_q[i])))
        |=> status_q[i]);
  end

endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] crit_sel,
  output logic               irq_norm_o,
  output logic               irq_crit_o
);

  logic [NUM_SRC-1:0] pend;
  logic norm_d, crit_d, norm_q, crit_q;

  always_comb begin
    pend   = status & enable;
    norm_d = |(pend & ~crit_sel);
    crit_d = |(pend & crit_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      norm_q <= norm_d;
      crit_q <= crit_d;
    end
  end

  assign irq_norm_o = norm_q;
  assign irq_crit_o = crit_q;

  assert_norm_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & enable & ~crit_sel)) |=> irq_norm_o);
  assert_norm_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & enable & ~crit_sel)) |=> !irq_norm_o);
  assert_crit_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & enable & crit_sel)) |=> irq_crit_o);
  assert_crit_falls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & enable & crit_sel)) |=> !irq_crit_o);

endmodule

// File: rtl/intc_dual_core.sv
module intc_dual_core
  import intc_dual_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BASE_ADDR = 'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  input  logic               reg_wr,
  input  logic               reg_rd,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_norm_o,
  output logic               irq_crit_o
);

  logic     hit;
  reg_ofs_e ofs;

  logic [NUM_SRC-1:0] src_bits;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable_q, crit_q, polar_q, trig_q;
  logic               wr_hit;
  logic               clr_we, set_we, en_we, crit_we, polar_we, trig_we;
  logic [NUM_SRC-1:0] rdata_d, rdata_q;

  // Source n lands on register bit NUM_SRC-1-n.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
    assign src_bits[NUM_SRC-1-n] = src_i[n];
  end

  intc_reg_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) i_decode (
    .addr (reg_addr),
    .hit  (hit),
    .ofs  (ofs)
  );

  always_comb begin
    wr_hit   = reg_wr && hit;
    clr_we   = wr_hit && (ofs == OFS_STAT);
    set_we   = wr_hit && (ofs == OFS_STAT_SET);
    en_we    = wr_hit && (ofs == OFS_ENABLE);
    crit_we  = wr_hit && (ofs == OFS_CRIT_SEL);
    polar_we = wr_hit && (ofs == OFS_POLAR);
    trig_we  = wr_hit && (ofs == OFS_TRIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      crit_q   <= '0;
      polar_q  <= '0;
      trig_q   <= '0;
    end else begin
      if (en_we)    enable_q <= reg_wdata;
      if (crit_we)  crit_q   <= reg_wdata;
      if (polar_we) polar_q  <= reg_wdata;
      if (trig_we)  trig_q   <= reg_wdata;
    end
  end

  intc_status_bank #(
    .NUM_SRC (NUM_SRC)
  ) i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_bits  (src_bits),
    .trig_edge (trig_q),
    .clr_we    (clr_we),
    .set_we    (set_we),
    .wdata     (reg_wdata),
    .status_o  (status)
  );

  intc_irq_out #(
    .NUM_SRC (NUM_SRC)
  ) i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status),
    .enable     (enable_q),
    .crit_sel   (crit_q),
    .irq_norm_o (irq_norm_o),
    .irq_crit_o (irq_crit_o)
  );

  always_comb begin
    rdata_d = '0;
    if (hit) begin
      case (ofs)
        OFS_STAT, OFS_STAT_SET: rdata_d = status;
        OFS_ENABLE:             rdata_d = enable_q;
        OFS_CRIT_SEL:           rdata_d = crit_q;
        OFS_POLAR:              rdata_d = polar_q;
        OFS_TRIG:               rdata_d = trig_q;
        OFS_MASKED:             rdata_d = status & enable_q;
        default:                rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  assert_undecoded_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hit) |=> (reg_rdata == '0));
  assert_vector_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit && ((ofs == OFS_VEC) || (ofs == OFS_VEC_CFG))) |=> (reg_rdata == '0));
  assert_readonly_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit && ((ofs == OFS_MASKED) || (ofs == OFS_VEC)))
      |=> ($stable(enable_q) && $stable(crit_q) && $stable(polar_q) && $stable(trig_q)));
  assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/test_intc_dual_core.sv
module test_intc_dual_core;

  localparam int unsigned NSRC   = 32;
  localparam int unsigned AW     = 10;
  localparam int unsigned BASE   = 'h140;
  localparam time         CLK_T  = 10ns;
  localparam int unsigned WD_CYC = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [AW-1:0]   addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic            wr = 1'b0;
  logic            rd = 1'b0;
  logic [NSRC-1:0] rdata;
  logic            irq_n, irq_c;

  int checks = 0;
  int fails  = 0;

  always #(CLK_T/2) clk = ~clk;

  intc_dual_core #(
    .NUM_SRC   (NSRC),
    .ADDR_W    (AW),
    .BASE_ADDR (BASE)
  ) i_intc_dual_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src),
    .reg_addr   (addr),
    .reg_wdata  (wdata),
    .reg_wr     (wr),
    .reg_rd     (rd),
    .reg_rdata  (rdata),
    .irq_norm_o (irq_n),
    .irq_crit_o (irq_c)
  );

  function automatic logic [NSRC-1:0] bsrc(input int n);
    return {{(NSRC-1){1'b0}}, 1'b1} << (NSRC-1-n);
  endfunction

  task automatic chk(input string tag, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [AW-1:0] a, input logic [NSRC-1:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_abs(input logic [AW-1:0] a, output logic [NSRC-1:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic wr_reg(input int ofs, input logic [NSRC-1:0] v);
    wr_abs(AW'(BASE + ofs), v);
  endtask

  task automatic rd_reg(input int ofs, output logic [NSRC-1:0] v);
    rd_abs(AW'(BASE + ofs), v);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic drive_src(input int n, input logic v);
    @(negedge clk);
    src[n] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NSRC-1:0] v;
    chk("R1 rdata after reset", rdata, '0);
    chk("R1 norm after reset", {31'b0, irq_n}, '0);
    chk("R1 crit after reset", {31'b0, irq_c}, '0);
    for (int k = 0; k < 9; k++) begin
      rd_reg(k, v);
      chk($sformatf("R1 offset %0d reset value", k), v, '0);
    end
  endtask

  task automatic t_mapping();
    logic [NSRC-1:0] v;
    drive_src(0, 1'b1);
    rd_reg(0, v);
    chk("R2 source 0 is MSB", v, bsrc(0));
    drive_src(0, 1'b0);
    drive_src(31, 1'b1);
    rd_reg(0, v);
    chk("R2 source 31 is LSB", v, 32'h0000_0001);
    drive_src(31, 1'b0);
    rd_reg(0, v);
    chk("R4 level source drops with input", v, '0);
  endtask

  task automatic t_edge();
    logic [NSRC-1:0] v;
    wr_reg(5, bsrc(3));
    wr_reg(2, bsrc(3));
    drive_src(3, 1'b1);
    rd_reg(0, v);
    chk("R3 rise sets status", v, bsrc(3));
    chk("R8 normal request from edge source", {31'b0, irq_n}, 32'h1);
    chk("R9 critical stays low", {31'b0, irq_c}, '0);
    drive_src(3, 1'b0);
    rd_reg(0, v);
    chk("R3 low input keeps latched bit", v, bsrc(3));
    wr_reg(0, bsrc(3));
    rd_reg(0, v);
    chk("R5 clear of edge bit", v, '0);
    chk("R8 normal drops after clear", {31'b0, irq_n}, '0);
    drive_src(3, 1'b1);
    wr_reg(0, bsrc(3));
    repeat (3) settle();
    rd_reg(0, v);
    chk("R3 steady high does not re-set", v, '0);
    drive_src(3, 1'b0);
    drive_src(3, 1'b1);
    rd_reg(0, v);
    chk("R3 new rise sets again", v, bsrc(3));
    drive_src(3, 1'b0);
    wr_reg(0, '1);
    wr_reg(5, '0);
    wr_reg(2, '0);
  endtask

  task automatic t_level_crit();
    logic [NSRC-1:0] v;
    wr_reg(2, bsrc(7));
    wr_reg(3, bsrc(7));
    drive_src(7, 1'b1);
    settle();
    rd_reg(0, v);
    chk("R4 level high sets status", v, bsrc(7));
    chk("R9 critical request", {31'b0, irq_c}, 32'h1);
    chk("R8 normal low for critical source", {31'b0, irq_n}, '0);
    wr_reg(0, '1);
    rd_reg(0, v);
    chk("R5 held level bit reasserted", v, bsrc(7));
    drive_src(7, 1'b0);
    rd_reg(0, v);
    chk("R4 level low clears status", v, '0);
    chk("R9 critical drops", {31'b0, irq_c}, '0);
    wr_reg(3, '0);
    wr_reg(2, '0);
  endtask

  task automatic t_set_masked();
    logic [NSRC-1:0] v;
    wr_reg(1, 32'hA500_0001);
    rd_reg(0, v);
    chk("R6 set via offset 1, read offset 0", v, 32'hA500_0001);
    rd_reg(1, v);
    chk("R6 read offset 1 returns status", v, 32'hA500_0001);
    wr_reg(1, 32'h0000_0100);
    rd_reg(0, v);
    chk("R6 set ORs into status", v, 32'hA500_0101);
    wr_reg(2, 32'hFF00_FF00);
    rd_reg(6, v);
    chk("R7 masked view", v, 32'hA500_0100);
    chk("R8 normal from set bits", {31'b0, irq_n}, 32'h1);
    wr_reg(3, '1);
    settle();
    chk("R9 critical after routing", {31'b0, irq_c}, 32'h1);
    chk("R8 normal after routing away", {31'b0, irq_n}, '0);
    wr_reg(6, '1);
    wr_reg(7, '1);
    settle();
    rd_reg(0, v);
    chk("R7 status untouched by offset 6/7 writes", v, 32'hA500_0101);
    rd_reg(2, v);
    chk("R7 enable untouched by offset 6/7 writes", v, 32'hFF00_FF00);
    rd_reg(3, v);
    chk("R7 critical-select untouched", v, '1);
    chk("R7 critical output unchanged", {31'b0, irq_c}, 32'h1);
    wr_reg(0, '1);
    settle();
    chk("R9 critical drops after clear", {31'b0, irq_c}, '0);
    wr_reg(3, '0);
  endtask

  task automatic t_polarity();
    logic [NSRC-1:0] v;
    wr_reg(4, 32'h1234_5678);
    rd_reg(4, v);
    chk("R10 polarity read back", v, 32'h1234_5678);
    settle();
    chk("R10 polarity does not raise normal", {31'b0, irq_n}, '0);
    chk("R10 polarity does not raise critical", {31'b0, irq_c}, '0);
    wr_reg(5, 32'hC3C3_0000);
    rd_reg(5, v);
    chk("R3 trigger-type read back", v, 32'hC3C3_0000);
    wr_reg(5, '0);
  endtask

  task automatic t_undecoded();
    logic [NSRC-1:0] v;
    wr_reg(1, 32'h0F00_0000);
    rd_abs(AW'(BASE - 1), v);
    chk("R11 below base reads zero", v, '0);
    rd_reg(9, v);
    chk("R11 offset 9 reads zero", v, '0);
    rd_reg(63, v);
    chk("R11 far offset reads zero", v, '0);
    rd_reg(7, v);
    chk("R11 offset 7 reads zero", v, '0);
    rd_reg(8, v);
    chk("R11 offset 8 reads zero", v, '0);
    wr_reg(9, '1);
    wr_abs(AW'(BASE - 1), '1);
    wr_reg(8, '1);
    rd_reg(2, v);
    chk("R11 stray writes leave enable", v, 32'hFF00_FF00);
    rd_reg(0, v);
    chk("R11 stray writes leave status", v, 32'h0F00_0000);
    rd_reg(8, v);
    chk("R11 offset 8 still zero after write", v, '0);
  endtask

  task automatic t_read_hold();
    logic [NSRC-1:0] v;
    rd_reg(0, v);
    chk("R12 read captures status", v, 32'h0F00_0000);
    wr_reg(0, '1);
    repeat (2) settle();
    chk("R12 read data holds without strobe", rdata, 32'h0F00_0000);
    rd_reg(0, v);
    chk("R12 new read shows cleared status", v, '0);
    wr_reg(2, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_mapping();
    t_edge();
    t_level_crit();
    t_set_masked();
    t_polarity();
    t_undecoded();
    t_read_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule